// File: doc/BRIEF.md
# Slot Frame Buffer with CPU Register Port

This block sits between a time-slot serial engine and a CPU. A processor reaches it through a small single-cycle slave port. The port has a 3-bit address, 8-bit data in each direction, strobe, cycle, write-enable, acknowledge and retry. The block holds one frame of transmit bytes and one frame of receive bytes, each in a 32-entry byte FIFO. It also holds the status, control and frame-length registers.

The block works on whole frames rather than on single bytes. At each frame boundary, the transmit side commits to sending a full frame only when enough bytes are already queued. Otherwise it sends all-ones for the whole frame and records an abort. The receive side collects one frame at a time. It refuses a new frame while the previous one has not been fully read, and records the loss.

Two level interrupts show that the transmit FIFO is empty and that a received frame is waiting. The engine side uses a frame-start pulse, one request strobe per transmit slot, and one push strobe per received slot. All engine-side strobes are sampled on the same clock as the CPU port.

Top module: `slot_frame_buffer`

## Requirements
- R1: After reset, the transmit status register (offset 0) reads 0x01 and the receive status register (offset 2) reads 0x00. The frame-length register (offset 4) reads 0xFF, `eng_slot_count` is 31, `eng_hdlc_en` is 0, `irq_tx_done` is 1 and `irq_rx_ready` is 0.
- R2: A write to offset 1 with fewer than 32 bytes queued is acknowledged and appends the byte to the transmit FIFO. When 32 bytes are queued, the write is answered with `wb_rty` instead of `wb_ack` and stores nothing.
- R3: Bit 0 of the transmit status register and `irq_tx_done` are 1 exactly while the transmit FIFO is empty.
- R4: The frame length L is bits 4:0 of the frame-length register plus one, captured at `frm_start`. If transmit is enabled (status bit 1) and at least L bytes are queued at `frm_start`, the first L slot requests of that frame return the queued bytes in write order, each removing its byte. Any later slot request in that frame returns 0xFF.
- R5: If transmit is enabled and fewer than L bytes are queued at `frm_start`, status bit 2 (abort) becomes 1, every slot request of that frame returns 0xFF, and the queue is left unchanged. When transmit is disabled, every slot request returns 0xFF and no abort is recorded.
- R6: The abort bit (transmit status bit 2) and the drop bit (receive status bit 1) stay at 1 until their status register is read. The read that clears a bit still returns it as 1.
- R7: At a `frm_start` with no frame held, the receive FIFO is emptied and collection begins. The first L bytes pushed in that frame are stored and later pushes are ignored. On the clock that stores the L-th byte, receive status bit 0 and `irq_rx_ready` become 1.
- R8: While a frame is held, each read of offset 3 is acknowledged and returns the next stored byte in arrival order. The flag in R7 clears after the L-th read. A read of offset 3 with no frame held is answered with `wb_rty`.
- R9: A `frm_start` while a frame is held discards the whole new frame and sets the drop bit. The held bytes and their order are unchanged.
- R10: Receive status bit 2 is 1 when any byte stored for the current frame was pushed with `rx_slot_err` high. It clears at the next `frm_start` that starts collection.
- R11: Offset 4 is readable and writable, and `eng_slot_count` equals its bits 4:0.
- R12: Writes to offset 0 store bit 1 (transmit enable) and bit 3 (serial-bypass enable), which read back at those positions. Bit 3 drives `eng_hdlc_en`.
- R13: `wb_ack` or `wb_rty` answers in the same cycle as `wb_stb` with `wb_cyc`, and never both. Offsets 5 to 7 are acknowledged, read as 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for both sides |
| rst_n | input | 1 | Synchronous reset, active low |
| wb_adr | input | 3 | Register offset |
| wb_dat_w | input | 8 | Write data from the CPU |
| wb_dat_r | output | 8 | Read data to the CPU, valid with `wb_ack` |
| wb_we | input | 1 | 1 for write, 0 for read |
| wb_stb | input | 1 | Access strobe |
| wb_cyc | input | 1 | Bus cycle active |
| wb_ack | output | 1 | Access completed |
| wb_rty | output | 1 | Access refused, retry later |
| irq_tx_done | output | 1 | Transmit FIFO empty |
| irq_rx_ready | output | 1 | Complete received frame waiting |
| frm_start | input | 1 | One-cycle frame boundary pulse |
| tx_slot_req | input | 1 | Engine asks for the byte of the next transmit slot |
| tx_slot_byte | output | 8 | Byte for the requested slot, valid with `tx_slot_req` |
| rx_slot_push | input | 1 | Engine offers a received slot byte |
| rx_slot_byte | input | 8 | Received slot byte |
| rx_slot_err | input | 1 | Error flag for the offered byte |
| eng_slot_count | output | 5 | Slots per frame minus one, for the engine |
| eng_hdlc_en | output | 1 | Serial-bypass enable for the engine |

## Verification
A lost write pointer, a frame committed against a short queue, or a frame-length snapshot that is not held would show up in `tx_slot_byte`. The value on the very slot request where the error occurs is a shifted or repeated byte, or 0xFF where data was due. Errors in the receive frame flag or the collection count show on `irq_rx_ready` one clock after the L-th push, or one clock after the L-th read. They also appear as bytes returned in the wrong order or as a retry answer on offset 3. Sticky-bit faults appear on the very next status read.

// File: rtl/sfb_pkg.sv
// Package: shared constants for the slot frame buffer.
// Assumes an 8-bit register file decoded on a 3-bit offset.
package sfb_pkg;
    localparam int DATA_W = 8;
    localparam int ADR_W  = 3;

    typedef enum logic [ADR_W-1:0] {
        OFS_TX_CTRL = 3'd0,
        OFS_TX_DATA = 3'd1,
        OFS_RX_CTRL = 3'd2,
        OFS_RX_DATA = 3'd3,
        OFS_FRM_LEN = 3'd4
    } reg_ofs_t;

    localparam logic [DATA_W-1:0] IDLE_BYTE = '1;
endpackage

// File: rtl/sfb_fifo.sv
// Module: synchronous byte FIFO with a clear input.
// Assumes pop on empty and push on full are filtered here; clear wins over push.
module sfb_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [AW:0]      count,
    output logic             full,
    output logic             empty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic             do_push;
    logic             do_pop;

    assign full    = (count == (AW+1)'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign dout    = mem[rd_ptr];

    // Storage write; no reset needed on the data array.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            end
            if (do_push && !do_pop) begin
                count <= count + 1'b1;
            end else if (do_pop && !do_push) begin
                count <= count - 1'b1;
            end
        end
    end
endmodule

// File: rtl/sfb_tx_sched.sv
// Module: decides once per frame whether queued bytes are sent or the
// frame is filled with idle ones, and feeds slot requests.
// Assumes no slot request is served in the frame-start cycle itself.
module sfb_tx_sched #(
    parameter int SLOTS = 32,
    localparam int LW   = $clog2(SLOTS) + 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frm_start,
    input  logic        slot_req,
    input  logic        tx_en,
    input  logic [LW-1:0] frame_len,
    input  logic [LW-1:0] fifo_count,
    input  logic [7:0]  fifo_head,
    output logic        fifo_pop,
    output logic [7:0]  slot_byte,
    output logic        abort_set
);
    logic          active;
    logic [LW-1:0] len_q;
    logic [LW-1:0] sent;
    logic          serve;
    logic          enough;

    assign enough    = (fifo_count >= frame_len);
    assign abort_set = frm_start && tx_en && !enough;
    assign serve     = slot_req && !frm_start && active && (sent < len_q);
    assign fifo_pop  = serve;
    assign slot_byte = serve ? fifo_head : sfb_pkg::IDLE_BYTE;

    // Per-frame commit decision and sent-byte tally.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            len_q  <= '0;
            sent   <= '0;
        end else if (frm_start) begin
            active <= tx_en && enough;
            len_q  <= frame_len;
            sent   <= '0;
        end else if (serve) begin
            sent <= sent + 1'b1;
        end
    end
endmodule

// File: rtl/sfb_rx_collect.sv
// Module: gathers one frame of received bytes, holds it until the CPU
// has read all of it, and discards frames that arrive meanwhile.
// Assumes the FIFO is at least one frame deep.
module sfb_rx_collect #(
    parameter int SLOTS = 32,
    localparam int LW   = $clog2(SLOTS) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frm_start,
    input  logic          slot_push,
    input  logic          slot_err,
    input  logic [LW-1:0] frame_len,
    input  logic          cpu_pop,
    input  logic [LW-1:0] fifo_count,
    output logic          fifo_push,
    output logic          fifo_clr,
    output logic          held,
    output logic          frame_err,
    output logic          drop_set
);
    logic          collecting;
    logic [LW-1:0] got;
    logic [LW-1:0] len_q;

    assign drop_set  = frm_start && held;
    assign fifo_clr  = frm_start && !held;
    assign fifo_push = slot_push && !frm_start && collecting && (got < len_q);

    // Collection window, byte tally and per-frame error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            collecting <= 1'b0;
            got        <= '0;
            len_q      <= '0;
            frame_err  <= 1'b0;
        end else if (frm_start) begin
            if (!held) begin
                collecting <= 1'b1;
                got        <= '0;
                len_q      <= frame_len;
                frame_err  <= 1'b0;
            end else begin
                collecting <= 1'b0;
            end
        end else if (fifo_push) begin
            got       <= got + 1'b1;
            frame_err <= frame_err | slot_err;
            if (got + 1'b1 == len_q) begin
                collecting <= 1'b0;
            end
        end
    end

    // Held-frame flag: set on the last stored byte, cleared by the last read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= 1'b0;
        end else if (fifo_push && (got + 1'b1 == len_q)) begin
            held <= 1'b1;
        end else if (cpu_pop && fifo_count == LW'(1)) begin
            held <= 1'b0;
        end
    end
endmodule

// File: rtl/slot_frame_buffer.sv
// Module: register-mapped frame buffer between a CPU slave port and a
// time-slot engine. Decodes the register file, answers each access in the
// same cycle with ACK or RTY, and keeps the sticky abort and drop bits.
// Assumes the master drops the strobe after one answered cycle.
module slot_frame_buffer #(
    parameter int SLOTS = 32,
    localparam int SW   = $clog2(SLOTS),
    localparam int LW   = SW + 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] wb_adr,
    input  logic [7:0] wb_dat_w,
    output logic [7:0] wb_dat_r,
    input  logic       wb_we,
    input  logic       wb_stb,
    input  logic       wb_cyc,
    output logic       wb_ack,
    output logic       wb_rty,
    output logic       irq_tx_done,
    output logic       irq_rx_ready,
    input  logic       frm_start,
    input  logic       tx_slot_req,
    output logic [7:0] tx_slot_byte,
    input  logic       rx_slot_push,
    input  logic [7:0] rx_slot_byte,
    input  logic       rx_slot_err,
    output logic [SW-1:0] eng_slot_count,
    output logic       eng_hdlc_en
);
    import sfb_pkg::*;

    logic          sel, tx_wr, rx_rd, rd_ack, wr_ack;
    logic          tx_en, hdlc_en, aborted, dropped;
    logic [7:0]    frm_len_reg;
    logic [LW-1:0] frame_len;
    logic [LW-1:0] tx_count, rx_count;
    logic          tx_full, tx_empty, tx_pop, abort_set;
    logic [7:0]    tx_head, rx_head;
    logic          rx_full, rx_empty, rx_push, rx_clr, rx_held, rx_ferr, drop_set;
    logic          rx_pop;

    assign frame_len = {1'b0, frm_len_reg[SW-1:0]} + 1'b1;

    // Access decode and same-cycle response.
    assign sel    = wb_stb && wb_cyc;
    assign tx_wr  = sel && wb_we && (wb_adr == OFS_TX_DATA);
    assign rx_rd  = sel && !wb_we && (wb_adr == OFS_RX_DATA);
    assign wb_rty = (tx_wr && tx_full) || (rx_rd && !rx_held);
    assign wb_ack = sel && !wb_rty;
    assign rd_ack = wb_ack && !wb_we;
    assign wr_ack = wb_ack && wb_we;
    assign rx_pop = rx_rd && rx_held;

    assign irq_tx_done    = tx_empty;
    assign irq_rx_ready   = rx_held;
    assign eng_slot_count = frm_len_reg[SW-1:0];
    assign eng_hdlc_en    = hdlc_en;

    // Read data mux.
    always_comb begin
        wb_dat_r = '0;
        case (wb_adr)
            OFS_TX_CTRL: wb_dat_r = {4'b0, hdlc_en, aborted, tx_en, tx_empty};
            OFS_RX_CTRL: wb_dat_r = {5'b0, rx_ferr, dropped, rx_held};
            OFS_RX_DATA: wb_dat_r = rx_head;
            OFS_FRM_LEN: wb_dat_r = frm_len_reg;
            default:     wb_dat_r = '0;
        endcase
    end

    // Writable control fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en       <= 1'b0;
            hdlc_en     <= 1'b0;
            frm_len_reg <= 8'hFF;
        end else if (wr_ack) begin
            if (wb_adr == OFS_TX_CTRL) begin
                tx_en   <= wb_dat_w[1];
                hdlc_en <= wb_dat_w[3];
            end
            if (wb_adr == OFS_FRM_LEN) begin
                frm_len_reg <= wb_dat_w;
            end
        end
    end

    // Sticky event bits: a new event wins over the clearing read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aborted <= 1'b0;
            dropped <= 1'b0;
        end else begin
            if (abort_set) begin
                aborted <= 1'b1;
            end else if (rd_ack && wb_adr == OFS_TX_CTRL) begin
                aborted <= 1'b0;
            end
            if (drop_set) begin
                dropped <= 1'b1;
            end else if (rd_ack && wb_adr == OFS_RX_CTRL) begin
                dropped <= 1'b0;
            end
        end
    end

    sfb_fifo #(.WIDTH(8), .DEPTH(SLOTS)) i_tx_fifo (
        .clk(clk), .rst_n(rst_n), .clr(1'b0),
        .push(tx_wr && !tx_full), .din(wb_dat_w),
        .pop(tx_pop), .dout(tx_head),
        .count(tx_count), .full(tx_full), .empty(tx_empty)
    );

    sfb_tx_sched #(.SLOTS(SLOTS)) i_tx_sched (
        .clk(clk), .rst_n(rst_n), .frm_start(frm_start),
        .slot_req(tx_slot_req), .tx_en(tx_en), .frame_len(frame_len),
        .fifo_count(tx_count), .fifo_head(tx_head), .fifo_pop(tx_pop),
        .slot_byte(tx_slot_byte), .abort_set(abort_set)
    );

    sfb_fifo #(.WIDTH(8), .DEPTH(SLOTS)) i_rx_fifo (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr),
        .push(rx_push), .din(rx_slot_byte),
        .pop(rx_pop), .dout(rx_head),
        .count(rx_count), .full(rx_full), .empty(rx_empty)
    );

    sfb_rx_collect #(.SLOTS(SLOTS)) i_rx_collect (
        .clk(clk), .rst_n(rst_n), .frm_start(frm_start),
        .slot_push(rx_slot_push), .slot_err(rx_slot_err),
        .frame_len(frame_len), .cpu_pop(rx_pop), .fifo_count(rx_count),
        .fifo_push(rx_push), .fifo_clr(rx_clr), .held(rx_held),
        .frame_err(rx_ferr), .drop_set(drop_set)
    );
endmodule

// File: rtl/sfb_checker.sv
// Checker: port-level properties of the slot frame buffer, bound to the top.
module sfb_checker #(
    parameter int SW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    wb_adr,
    input logic [7:0]    wb_dat_w,
    input logic          wb_we,
    input logic          wb_stb,
    input logic          wb_cyc,
    input logic          wb_ack,
    input logic          wb_rty,
    input logic          irq_tx_done,
    input logic          irq_rx_ready,
    input logic          rx_slot_push,
    input logic [SW-1:0] eng_slot_count
);
    AST_ACK_RTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_ack && wb_rty)); // R13

    AST_RESP_NEEDS_STB: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_ack || wb_rty) |-> (wb_stb && wb_cyc)); // R13

    AST_TXWR_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_ack && wb_we && wb_adr == 3'd1) |=> !irq_tx_done); // R3

    AST_RXREADY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_rx_ready) |-> $past(rx_slot_push)); // R7

    AST_RXREADY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_rx_ready) |-> $past(wb_ack && !wb_we && wb_adr == 3'd3)); // R8

    AST_SLOT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_ack && wb_we && wb_adr == 3'd4) |=> (eng_slot_count == $past(wb_dat_w[SW-1:0]))); // R11
endmodule

bind slot_frame_buffer sfb_checker #(.SW(SW)) i_sfb_checker (
    .clk(clk), .rst_n(rst_n), .wb_adr(wb_adr), .wb_dat_w(wb_dat_w),
    .wb_we(wb_we), .wb_stb(wb_stb), .wb_cyc(wb_cyc), .wb_ack(wb_ack),
    .wb_rty(wb_rty), .irq_tx_done(irq_tx_done), .irq_rx_ready(irq_rx_ready),
    .rx_slot_push(rx_slot_push), .eng_slot_count(eng_slot_count)
);

// File: tb/test_slot_frame_buffer.sv
module test_slot_frame_buffer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] wb_adr = '0;
    logic [7:0] wb_dat_w = '0;
    logic [7:0] wb_dat_r;
    logic       wb_we = 1'b0, wb_stb = 1'b0, wb_cyc = 1'b0;
    logic       wb_ack, wb_rty, irq_tx_done, irq_rx_ready;
    logic       frm_start = 1'b0, tx_slot_req = 1'b0;
    logic [7:0] tx_slot_byte;
    logic       rx_slot_push = 1'b0;
    logic [7:0] rx_slot_byte = '0;
    logic       rx_slot_err = 1'b0;
    logic [4:0] eng_slot_count;
    logic       eng_hdlc_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    byte unsigned txq[$];
    byte unsigned rxq[$];
    logic [7:0] rd;
    logic       ack, rty;

    always #4 clk = ~clk;

    slot_frame_buffer i_slot_frame_buffer (
        .clk(clk), .rst_n(rst_n), .wb_adr(wb_adr), .wb_dat_w(wb_dat_w),
        .wb_dat_r(wb_dat_r), .wb_we(wb_we), .wb_stb(wb_stb), .wb_cyc(wb_cyc),
        .wb_ack(wb_ack), .wb_rty(wb_rty), .irq_tx_done(irq_tx_done),
        .irq_rx_ready(irq_rx_ready), .frm_start(frm_start),
        .tx_slot_req(tx_slot_req), .tx_slot_byte(tx_slot_byte),
        .rx_slot_push(rx_slot_push), .rx_slot_byte(rx_slot_byte),
        .rx_slot_err(rx_slot_err), .eng_slot_count(eng_slot_count),
        .eng_hdlc_en(eng_hdlc_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] tx_stat(input bit en, input bit hd, input bit ab);
        return {4'b0, hd, ab, en, (txq.size() == 0)};
    endfunction

    task automatic cpu(input logic [2:0] a, input bit we, input logic [7:0] d);
        @(negedge clk);
        wb_adr = a; wb_we = we; wb_dat_w = d; wb_stb = 1'b1; wb_cyc = 1'b1;
        #1;
        rd = wb_dat_r; ack = wb_ack; rty = wb_rty;
        @(posedge clk);
        #1;
        wb_stb = 1'b0; wb_cyc = 1'b0; wb_we = 1'b0;
    endtask

    task automatic frame_pulse();
        @(negedge clk);
        frm_start = 1'b1;
        @(posedge clk);
        #1;
        frm_start = 1'b0;
    endtask

    task automatic slot(output logic [7:0] b);
        @(negedge clk);
        tx_slot_req = 1'b1;
        #1;
        b = tx_slot_byte;
        @(posedge clk);
        #1;
        tx_slot_req = 1'b0;
    endtask

    task automatic push(input logic [7:0] b, input bit e);
        @(negedge clk);
        rx_slot_push = 1'b1; rx_slot_byte = b; rx_slot_err = e;
        @(posedge clk);
        #1;
        rx_slot_push = 1'b0; rx_slot_err = 1'b0;
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        logic [7:0] b;
        int len;
        bit act;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        cpu(3'd0, 0, 0); chk("R1 txstat", rd, 8'h01);
        cpu(3'd2, 0, 0); chk("R1 rxstat", rd, 8'h00);
        cpu(3'd4, 0, 0); chk("R1 frmlen", rd, 8'hFF);
        chk("R1 slotcnt", eng_slot_count, 31);
        chk("R1 hdlc", eng_hdlc_en, 0);
        chk("R1 irq_tx", irq_tx_done, 1);
        chk("R1 irq_rx", irq_rx_ready, 0);

        // R11 frame length register
        cpu(3'd4, 1, 8'hE3); cpu(3'd4, 0, 0);
        chk("R11 readback", rd, 8'hE3);
        chk("R11 slotcnt", eng_slot_count, 3);

        // R12 enable bits
        cpu(3'd0, 1, 8'h0A); cpu(3'd0, 0, 0);
        chk("R12 readback", rd, tx_stat(1, 1, 0));
        chk("R12 hdlc pin", eng_hdlc_en, 1);
        cpu(3'd0, 1, 8'h02);
        chk("R12 hdlc off", eng_hdlc_en, 0);

        // R5 abort with empty queue, R6 sticky clear on read
        frame_pulse();
        slot(b); chk("R5 ones slot0", b, 8'hFF);
        slot(b); chk("R5 ones slot1", b, 8'hFF);
        cpu(3'd0, 0, 0); chk("R6 abort read", rd, tx_stat(1, 0, 1));
        cpu(3'd0, 0, 0); chk("R6 abort cleared", rd, tx_stat(1, 0, 0));

        // R2 fill to full, R3 empty flag
        for (int i = 0; i < 32; i++) begin
            b = 8'($urandom);
            cpu(3'd1, 1, b);
            txq.push_back(b);
            chk("R2 write ack", ack, 1);
        end
        chk("R3 irq not empty", irq_tx_done, 0);
        cpu(3'd1, 1, 8'h5A);
        chk("R2 full rty", rty, 1);
        chk("R2 full no ack", ack, 0);

        // R4/R5 random frames against the queue model
        for (int it = 0; it < 12; it++) begin
            len = int'($urandom % 32) + 1;
            cpu(3'd4, 1, 8'(len - 1));
            if (it > 0) begin
                for (int k = int'($urandom % (33 - txq.size())); k > 0; k--) begin
                    b = 8'($urandom);
                    cpu(3'd1, 1, b);
                    txq.push_back(b);
                end
            end
            act = (txq.size() >= len);
            frame_pulse();
            for (int s = 0; s < len + 1; s++) begin
                slot(b);
                if (act && s < len) chk("R4 slot byte", b, txq.pop_front());
                else chk("R5 idle slot", b, 8'hFF);
            end
            cpu(3'd0, 0, 0); chk("R3 R5 status", rd, tx_stat(1, 0, !act));
            chk("R3 irq", irq_tx_done, txq.size() == 0);
        end

        // R5 disabled transmit: ones, no abort, queue kept
        cpu(3'd4, 1, 8'd0);
        if (txq.size() == 0) begin
            cpu(3'd1, 1, 8'h77); txq.push_back(8'h77);
        end
        cpu(3'd0, 1, 8'h00);
        frame_pulse();
        slot(b); chk("R5 disabled ones", b, 8'hFF);
        cpu(3'd0, 0, 0); chk("R5 no abort", rd, tx_stat(0, 0, 0));
        cpu(3'd0, 1, 8'h02);
        frame_pulse();
        slot(b); chk("R5 queue kept", b, txq.pop_front());

        // R8 read with no frame held
        cpu(3'd3, 0, 0); chk("R8 empty rty", rty, 1);

        // R7/R8/R10 random receive frames
        for (int it = 0; it < 8; it++) begin
            bit e, eexp;
            len = int'($urandom % 32) + 1;
            cpu(3'd4, 1, 8'(len - 1));
            frame_pulse();
            rxq.delete();
            eexp = 0;
            for (int s = 0; s < len; s++) begin
                b = 8'($urandom);
                e = (it == 3 && s == len - 1);
                push(b, e);
                rxq.push_back(b);
                eexp |= e;
                if (s < len - 1) chk("R7 not ready early", irq_rx_ready, 0);
            end
            chk("R7 ready after frame", irq_rx_ready, 1);
            push(8'hC3, 1);
            cpu(3'd2, 0, 0); chk("R10 R7 rxstat", rd, {5'b0, eexp, 1'b0, 1'b1});
            for (int s = 0; s < len; s++) begin
                cpu(3'd3, 0, 0);
                chk("R8 read ack", ack, 1);
                chk("R8 read byte", rd, rxq.pop_front());
            end
            chk("R8 ready cleared", irq_rx_ready, 0);
        end

        // R9 drop while held, R10 error clears on next accepted frame
        cpu(3'd4, 1, 8'd2);
        frame_pulse();
        push(8'h11, 0); push(8'h22, 0); push(8'h33, 0);
        frame_pulse();
        push(8'hAA, 1); push(8'hBB, 1); push(8'hCC, 1);
        cpu(3'd2, 0, 0); chk("R9 drop set", rd, 8'h03);
        cpu(3'd2, 0, 0); chk("R6 drop cleared", rd, 8'h01);
        cpu(3'd3, 0, 0); chk("R9 held byte0", rd, 8'h11);
        cpu(3'd3, 0, 0); chk("R9 held byte1", rd, 8'h22);
        cpu(3'd3, 0, 0); chk("R9 held byte2", rd, 8'h33);
        cpu(3'd3, 0, 0); chk("R9 no extra", rty, 1);

        // R13 unused offsets
        cpu(3'd5, 1, 8'h5C); chk("R13 write ack", ack, 1);
        cpu(3'd5, 0, 0); chk("R13 reads zero", rd, 8'h00);
        cpu(3'd4, 0, 0); chk("R13 no side effect", rd, 8'h02);

        done = 1'b1;
        report();
    end
endmodule